// File: doc/BRIEF.md
# Fan Tachometer Period Counter

This block measures the rotation speed of up to five fans by timing their tachometer pulses. Each tachometer line is synchronized into the system clock domain. A free-running reference tick, one tick every `REF_DIV` system clocks, is counted between successive rising edges of that line. The count held at each edge becomes the channel's reported measurement. The host converts the count to a speed in software.

Three of the channels can report in two ways:

- **Wide mode:** a full 16-bit count.
- **Narrow mode:** an 8-bit count that is first divided by a per-channel power of two. In this mode 0xFF flags overflow, and the host reacts by raising that channel's divisor.

The remaining two channels always report 16 bits.

A stopped fan produces no edges. Its count saturates, so it reads as all-ones.

The host reads and writes byte registers through a simple address/strobe port. Reading a channel's low byte captures its high byte, so a two-read sequence always returns one coherent 16-bit value.

Top module: `fan_tach_meter`

## Requirements
- R1: After reset the control (address 0), extension (address 1) and divisor (address 2) registers read 0x00, every channel is disabled, and every count byte reads 0x00.
- R2: Channel enables are split across two registers. Channels 0, 1 and 2 are enabled by bits 4, 5 and 6 of address 0. Channels 3 and 4 are enabled by bits 4 and 5 of address 1. While a channel is disabled, its count reads 0 and its counting is cleared.
- R3: For channel i in 0..2, bit i of address 1 selects wide mode; channels 3 and 4 are always wide. In wide mode the count equals the number of reference ticks between two successive synchronized rising edges of the tachometer line. The count is updated at each rising edge and holds its value between edges.
- R4: In wide mode, an input with no rising edge for 65535 or more ticks reads 0xFFFF. The count saturates and never wraps.
- R5: In narrow mode the count is min(ticks >> shift, 0xFF), and the channel's high byte reads 0x00.
- R6: The shift amounts come from address 2. Channel 0 takes bits 2:0 and channel 1 takes bits 5:3. Channel 2 uses bit 6: a value of 1 means a shift of 3, and 0 means a shift of 1.
- R7: In narrow mode, a scaled period above 254 reads 0xFF, including a stalled input.
- R8: Channel i's count is read at addresses 4+i (low byte) and 9+i (high byte). A read of the low byte captures the high byte. A read of the high byte returns the captured value, even if the count has changed since the low-byte read.
- R9: Each tachometer line passes through a two-flop synchronizer. Only rising edges are timed, and each rising edge yields a one-cycle internal event.
- R10: The reference tick occurs once every `REF_DIV` system clocks. With `REF_DIV` = 1 the count is the period in system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tach_in | input | 5 | Asynchronous tachometer lines, bit i for channel i |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; side effect on low count bytes |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |

## Verification
Channel 0 in wide mode is swept over every period from 4 to 40 clocks, which separates an exact count from one that is off by a cycle. Other channels then run at unrelated periods at the same time, which shows that the channels are independent.

In narrow mode a fixed 600-clock period is read under each of the eight shifts of channel 0. Both encodings of channel 2 are read as well. This separates the truncating division from the overflow code.

A held-low line shows that the count saturates rather than wraps in both modes. A period change between the low-byte and high-byte reads shows that the high byte comes from the capture and not from the live count.

// File: rtl/fan_tach_pkg.sv
package fan_tach_pkg;
  localparam int NUM_CH  = 5;   // channels in the register map
  localparam int SEL_CH  = 3;   // channels with selectable width
  localparam int CNT_W   = 16;  // wide result width
  localparam int MAX_SH  = 7;   // largest shift amount
  localparam int RAW_W   = CNT_W + MAX_SH;
  localparam int LO_BASE = 4;   // low-byte addresses start here
  localparam int HI_BASE = LO_BASE + NUM_CH;

  // saturating increment of the raw tick counter
  function automatic logic [RAW_W-1:0] sat_inc(input logic [RAW_W-1:0] v, input logic inc);
    if (&v) return v;
    return v + RAW_W'(inc);
  endfunction

  // scale a raw tick count into the reported value
  function automatic logic [CNT_W-1:0] scale_count(input logic [RAW_W-1:0] raw,
                                                   input logic wide,
                                                   input logic [2:0] sh);
    logic [RAW_W-1:0] t;
    if (wide) begin
      if (raw > RAW_W'(16'hFFFF)) return 16'hFFFF;
      return raw[CNT_W-1:0];
    end
    t = raw >> sh;
    if (t > RAW_W'(8'hFF)) return 16'h00FF;
    return {8'h00, t[7:0]};
  endfunction

  // full-scale value for the mode
  function automatic logic [CNT_W-1:0] full_scale(input logic wide);
    return wide ? 16'hFFFF : 16'h00FF;
  endfunction

  // shift amount for a channel from the divisor byte
  function automatic logic [2:0] shift_for(input int ch, input logic [7:0] dv);
    case (ch)
      0:       return dv[2:0];
      1:       return dv[5:3];
      2:       return dv[6] ? 3'd3 : 3'd1;
      default: return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/fan_tach_sync.sv
module fan_tach_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic s1, s2, s3;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= din;
      s2 <= s1;
      s3 <= s2;
    end
  end
  assign rise = s2 & ~s3;
endmodule

// File: rtl/fan_tach_chan.sv
module fan_tach_chan
  import fan_tach_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             en,
  input  logic             rise,
  input  logic             wide,
  input  logic [2:0]       shift,
  output logic [CNT_W-1:0] meas,
  output logic             sat_hit
);
  logic [RAW_W-1:0] raw, raw_nxt;
  logic [CNT_W-1:0] val;

  always_comb begin
    raw_nxt = sat_inc(raw, tick);
    val     = scale_count(raw_nxt, wide, shift);
    sat_hit = en && (val == full_scale(wide));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw  <= '0;
      meas <= '0;
    end else if (!en) begin
      raw  <= '0;
      meas <= '0;
    end else if (rise) begin
      raw  <= '0;
      meas <= val;
    end else begin
      raw <= raw_nxt;
      if (sat_hit) meas <= val;
    end
  end
endmodule

// File: rtl/fan_tach_regs.sv
module fan_tach_regs
  import fan_tach_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic                         rd_en,
  input  logic [3:0]                   addr,
  input  logic [7:0]                   wdata,
  input  logic [NUM_CH-1:0][CNT_W-1:0] meas,
  output logic [7:0]                   rdata,
  output logic [NUM_CH-1:0]            ch_en,
  output logic [NUM_CH-1:0]            wide,
  output logic [7:0]                   div_q,
  output logic [NUM_CH-1:0][7:0]       hi_snap
);
  logic [7:0] ctl_q, ext_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      ext_q   <= '0;
      div_q   <= '0;
      hi_snap <= '0;
    end else begin
      if (wr_en) begin
        case (addr)
          4'd0:    ctl_q <= wdata & 8'h70;
          4'd1:    ext_q <= wdata & 8'h37;
          4'd2:    div_q <= wdata & 8'h7F;
          default: ;
        endcase
      end
      if (rd_en) begin
        for (int i = 0; i < NUM_CH; i++)
          if (addr == 4'(LO_BASE + i)) hi_snap[i] <= meas[i][15:8];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      if (i < SEL_CH) begin
        ch_en[i] = ctl_q[4+i];
        wide[i]  = ext_q[i];
      end else begin
        ch_en[i] = ext_q[4+i-SEL_CH];
        wide[i]  = 1'b1;
      end
    end
  end

  always_comb begin
    rdata = 8'h00;
    case (addr)
      4'd0:    rdata = ctl_q;
      4'd1:    rdata = ext_q;
      4'd2:    rdata = div_q;
      default: ;
    endcase
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr == 4'(LO_BASE + i)) rdata = meas[i][7:0];
      if (addr == 4'(HI_BASE + i)) rdata = hi_snap[i];
    end
  end
endmodule

// File: rtl/fan_tach_meter.sv
module fan_tach_meter
  import fan_tach_pkg::*;
#(
  parameter int REF_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] tach_in,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [3:0]        addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);
  localparam int TW = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;

  logic                         tick;
  logic [NUM_CH-1:0]            rise;
  logic [NUM_CH-1:0]            ch_en;
  logic [NUM_CH-1:0]            wide;
  logic [NUM_CH-1:0]            sat_hit;
  logic [NUM_CH-1:0][CNT_W-1:0] meas;
  logic [NUM_CH-1:0][7:0]       hi_snap;
  logic [7:0]                   div_q;

  generate
    if (REF_DIV <= 1) begin : g_tick_every
      assign tick = 1'b1;
    end else begin : g_tick_div
      logic [TW-1:0] tcnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          tcnt <= '0;
        else if (tcnt == TW'(REF_DIV - 1))   tcnt <= '0;
        else                                 tcnt <= tcnt + 1'b1;
      end
      assign tick = (tcnt == TW'(REF_DIV - 1));
    end
  endgenerate

  fan_tach_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .meas(meas), .rdata(rdata), .ch_en(ch_en), .wide(wide),
    .div_q(div_q), .hi_snap(hi_snap)
  );

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      fan_tach_sync u_sync (
        .clk(clk), .rst_n(rst_n), .din(tach_in[g]), .rise(rise[g])
      );
      fan_tach_chan u_chan (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(ch_en[g]), .rise(rise[g]),
        .wide(wide[g]), .shift(shift_for(g, div_q)),
        .meas(meas[g]), .sat_hit(sat_hit[g])
      );
    end
  endgenerate
endmodule

// File: rtl/fan_tach_checker.sv
module fan_tach_checker
  import fan_tach_pkg::*;
(
  input logic                         clk,
  input logic                         rst_n,
  input logic                         rd_en,
  input logic [3:0]                   addr,
  input logic [NUM_CH-1:0]            rise,
  input logic [NUM_CH-1:0]            ch_en,
  input logic [NUM_CH-1:0]            wide,
  input logic [NUM_CH-1:0]            sat_hit,
  input logic [NUM_CH-1:0][CNT_W-1:0] meas,
  input logic [NUM_CH-1:0][7:0]       hi_snap
);
  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
      // R9: a synchronized rising edge lasts one cycle
      a_r9_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise[g] |=> !rise[g]);
      // R2: a disabled channel reports zero
      a_r2_disabled_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_en[g] |=> meas[g] == '0);
      // R3: result holds between edges unless saturating
      a_r3_hold_between_edges: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_en[g] && !rise[g] && !sat_hit[g]) |=> $stable(meas[g]));
      // R5: narrow results carry a zero high byte
      a_r5_narrow_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_en[g] && rise[g] && !wide[g]) |=> meas[g][15:8] == 8'h00);
      // R8: a low-byte read captures the high byte
      a_r8_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 4'(LO_BASE + g)) |=> hi_snap[g] == $past(meas[g][15:8]));
    end
  endgenerate
endmodule

bind fan_tach_meter fan_tach_checker u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .rise(rise),
  .ch_en(ch_en), .wide(wide), .sat_hit(sat_hit), .meas(meas), .hi_snap(hi_snap)
);

// File: tb/tb_fan_tach_meter.sv
`timescale 1ns/1ps
module tb_fan_tach_meter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] tach_in = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  int         per [5];
  int         n_run = 0, n_fail = 0;
  bit         done = 0;

  always #4 clk = ~clk;

  fan_tach_meter #(.REF_DIV(1)) dut (
    .clk(clk), .rst_n(rst_n), .tach_in(tach_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  generate
    for (genvar g = 0; g < 5; g++) begin : g_drv
      initial begin
        per[g] = 0;
        forever begin
          if (per[g] == 0) begin
            tach_in[g] = 1'b0;
            @(negedge clk);
          end else begin
            tach_in[g] = 1'b1;
            repeat (per[g] / 2) @(negedge clk);
            tach_in[g] = 1'b0;
            repeat (per[g] - per[g] / 2) @(negedge clk);
          end
        end
      end
    end
  endgenerate

  task automatic check(input string req, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    addr = 4'(a); wdata = 8'(d); wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    addr = 4'(a); rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd16(input int ch, output int v);
    int lo, hi;
    rd(4 + ch, lo);
    rd(9 + ch, hi);
    v = hi * 256 + lo;
  endtask

  function automatic int narrow(input int p, input int sh);
    int t = p >> sh;
    return (t > 255) ? 255 : t;
  endfunction

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd(0, v); check("R1 ctrl", v, 0);
    rd(1, v); check("R1 ext", v, 0);
    rd(2, v); check("R1 div", v, 0);
    for (int c = 0; c < 5; c++) begin rd16(c, v); check("R1 count", v, 0); end

    // R2 disabled channel ignores pulses
    per[0] = 30;
    repeat (200) @(negedge clk);
    rd16(0, v); check("R2 disabled reads 0", v, 0);

    // R3/R10: all channels wide, distinct periods
    wr(1, 8'h37); wr(0, 8'h70);
    per[0] = 40; per[1] = 57; per[2] = 100; per[3] = 333; per[4] = 1000;
    repeat (3100) @(negedge clk);
    for (int c = 0; c < 5; c++) begin
      rd16(c, v); check("R3 wide count", v, per[c]);
    end

    // R3/R9: period sweep on channel 0
    for (int p = 4; p <= 40; p++) begin
      per[0] = p;
      repeat (3 * p + 20) @(negedge clk);
      rd16(0, v); check("R3 sweep", v, p);
    end

    // R5/R6: narrow mode with divisors
    wr(1, 8'h30);
    wr(2, 8'h42);                // ch0 shift 2, ch1 shift 0, ch2 shift 3
    per[0] = 100; per[1] = 200; per[2] = 400;
    repeat (1400) @(negedge clk);
    rd16(0, v); check("R5 ch0 shift2", v, narrow(100, 2));
    rd16(1, v); check("R6 ch1 shift0", v, narrow(200, 0));
    rd16(2, v); check("R6 ch2 bit6 shift3", v, narrow(400, 3));
    rd16(3, v); check("R3 ch3 stays wide", v, 333);

    // R7: overflow on channel 1
    per[1] = 300;
    repeat (1000) @(negedge clk);
    rd16(1, v); check("R7 overflow", v, 255);

    // R6: channel 2 with bit6 clear -> shift 1
    wr(2, 8'h02);
    repeat (1300) @(negedge clk);
    rd16(2, v); check("R6 ch2 shift1", v, narrow(400, 1));

    // R5/R6: all shifts on channel 0
    per[0] = 600;
    for (int s = 0; s < 8; s++) begin
      wr(2, s);
      repeat (1900) @(negedge clk);
      rd16(0, v); check("R6 ch0 shift sweep", v, narrow(600, s));
    end

    // R8: high byte comes from the capture
    per[4] = 1000;
    repeat (2100) @(negedge clk);
    rd(4 + 4, v); check("R8 low byte", v, 1000 & 255);
    per[4] = 700;
    repeat (2200) @(negedge clk);
    rd(9 + 4, v); check("R8 captured high", v, 1000 >> 8);
    rd16(4, v); check("R8 fresh pair", v, 700);

    // R4/R7: stalled inputs saturate
    wr(2, 8'h00);
    per[0] = 0; per[3] = 0;
    repeat (66000) @(negedge clk);
    rd16(0, v); check("R7 narrow stall", v, 255);
    rd16(3, v); check("R4 wide stall", v, 16'hFFFF);

    // R2: disabling clears
    wr(0, 8'h00);
    rd16(1, v); check("R2 cleared on disable", v, 0);
    rd16(3, v); check("R2 ch3 unaffected by ctrl", v, 16'hFFFF);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule